// File: doc/BRIEF.md
# Three-Wire Display Memory and Command Interface

This block is the device side of a slow three-wire host link used to drive a segment display controller. The host lowers an active-low select line, clocks bits in with a write strobe and clocks bits out with a read strobe, all over a single data line whose direction the block controls. Every session opens with a 3-bit identifier. The identifier either starts a display-memory transfer, made of a 7-bit address and then 4-bit nibbles, or starts a stream of 9-bit command words.

The strobes are slow compared with the system clock. The block samples them on `clk`, finds their edges, and turns each session into single-cycle events. Reads and writes of the display memory appear on an address/strobe port that expects a combinational read. Each complete command appears as a one-cycle pulse carrying its code. The memory array and the effect of each command live outside this block.

Top module: `disp_serial_if`

## Requirements
- R1: After reset, and for as long as `cs_n` is high, `dat_oe` is 0 and none of `mem_rd_en`, `mem_wr_en` or `cmd_valid` is asserted.
- R2: The first three bits of a session, taken on rising edges of `wr_n` with the first bit as the most significant, select the mode: 110 is read, 101 is write or read-modify-write, 100 is command. Any other identifier makes the block ignore the rest of the session, so no strobe and no command appear until `cs_n` goes high.
- R3: In the data modes the identifier is followed by seven address bits, sent most significant first. Write nibbles are then taken least significant bit first, each bit sampled on a rising edge of `wr_n`.
- R4: When the fourth bit of a write nibble arrives, `mem_wr_en` pulses for one cycle with `mem_addr` and `mem_wr_data` valid. The next nibble goes to the next address.
- R5: In read mode (110), the `rd_n` falling edge that starts a nibble pulses `mem_rd_en` for one cycle. Each `rd_n` falling edge drives the next bit onto `dat_out`, bit 0 first. After four bits the address advances and the following falling edge starts the next nibble.
- R6: In mode 101 a nibble may first be read with four `rd_n` cycles and then be overwritten with four `wr_n` cycles at the same address. The address advances only after the write.
- R7: In command mode every nine bits, most significant first, produce a one-cycle `cmd_valid` with `cmd_code`. Further commands follow in the same session without another identifier.
- R8: A high `cs_n` discards any partial identifier, address, nibble or command. The next session must start with a new identifier.
- R9: When the address advances from 95 it goes to 0.
- R10: An access to an address from 96 to 127 makes no `mem_rd_en` and no `mem_wr_en`, and a read there drives 0 on every bit.
- R11: `dat_oe` is 1 from the `rd_n` falling edge that drives the first bit of a nibble until the `rd_n` rising edge after its fourth bit, and a `wr_n` falling edge releases it at once. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low session select |
| wr_n | input | 1 | Host write strobe; bits taken on its rising edge |
| rd_n | input | 1 | Host read strobe; bits driven on its falling edge |
| dat_in | input | 1 | Serial data from the host |
| dat_out | output | 1 | Serial data to the host |
| dat_oe | output | 1 | Drive enable for the shared data line |
| mem_addr | output | 7 | Display memory address |
| mem_rd_en | output | 1 | One-cycle memory read strobe |
| mem_rd_data | input | 4 | Memory read data, valid in the strobe cycle |
| mem_wr_en | output | 1 | One-cycle memory write strobe |
| mem_wr_data | output | 4 | Memory write data |
| cmd_valid | output | 1 | One-cycle pulse for a complete command |
| cmd_code | output | 9 | Command word |

## Verification
The bench attacks the bit order by writing nibbles whose reversed value differs, so a design that shifts data most significant first stores the wrong value. It runs write and read bursts across 95 into 0 and uses addresses above 95. A design that wraps only at 127, or that strobes outside the array, shows up as a wrong location or an extra strobe count. In read-modify-write it reads back the old nibble before writing, which catches a design that advances the address after the read half. It also drops `cs_n` in the middle of an address, a nibble or a command to catch state that leaks into the next session, and it sends unknown identifiers to confirm those sessions stay silent.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] ID_READ  = 3'b110;
    localparam logic [MODE_W-1:0] ID_WRITE = 3'b101;
    localparam logic [MODE_W-1:0] ID_CMD   = 3'b100;

    typedef enum logic [2:0] {
        PH_MODE,
        PH_ADDR,
        PH_DATA,
        PH_CMD,
        PH_DEAD
    } phase_t;

    typedef enum logic {
        K_RD,
        K_WR
    } kind_t;

    typedef struct packed {
        phase_t ph;
        kind_t  kind;
    } id_dec_t;

    function automatic id_dec_t decode_id(input logic [MODE_W-1:0] id);
        id_dec_t r;
        case (id)
            ID_READ:  r = '{ph: PH_ADDR, kind: K_RD};
            ID_WRITE: r = '{ph: PH_ADDR, kind: K_WR};
            ID_CMD:   r = '{ph: PH_CMD,  kind: K_RD};
            default:  r = '{ph: PH_DEAD, kind: K_RD};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsi_edge.sv
module dsi_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_n,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= line_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign rise[i] =  line_n[i] & ~q[i];
        assign fall[i] = ~line_n[i] &  q[i];
    end

endmodule

// File: rtl/dsi_frame.sv
module dsi_frame
    import dsi_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CMD_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_rise,
    input  logic              din,
    output phase_t            phase,
    output kind_t             kind,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_code
);
    localparam int SH_W  = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
    localparam int CNT_W = $clog2(SH_W + 1);

    logic [SH_W-1:0]   sh;
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] id_now;
    logic [ADDR_W-1:0] addr_now;
    logic [CMD_W-1:0]  cmd_now;
    id_dec_t           dec;

    always_comb begin
        id_now   = {sh[MODE_W-2:0], din};
        addr_now = {sh[ADDR_W-2:0], din};
        cmd_now  = {sh[CMD_W-2:0], din};
        dec      = decode_id(id_now);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            phase     <= PH_MODE;
            kind      <= K_RD;
            sh        <= '0;
            cnt       <= '0;
            addr_load <= 1'b0;
            addr_val  <= '0;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            addr_load <= 1'b0;
            cmd_valid <= 1'b0;
            if (wr_rise) begin
                sh  <= {sh[SH_W-2:0], din};
                cnt <= cnt + 1'b1;
                case (phase)
                    PH_MODE: if (cnt == CNT_W'(MODE_W - 1)) begin
                        cnt   <= '0;
                        phase <= dec.ph;
                        kind  <= dec.kind;
                    end
                    PH_ADDR: if (cnt == CNT_W'(ADDR_W - 1)) begin
                        cnt       <= '0;
                        phase     <= PH_DATA;
                        addr_load <= 1'b1;
                        addr_val  <= addr_now;
                    end
                    PH_CMD: if (cnt == CNT_W'(CMD_W - 1)) begin
                        cnt       <= '0;
                        cmd_valid <= 1'b1;
                        cmd_code  <= cmd_now;
                    end
                    default: cnt <= cnt;
                endcase
            end
        end
    end

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);                                   // R7
    AST_CMD_IN_CMD_PHASE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (phase == PH_CMD));                            // R7
    AST_BAD_ID_STAYS_DEAD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEAD && !cs_n) |=> (phase == PH_DEAD));         // R2
    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (phase == PH_MODE && !cmd_valid && !addr_load));    // R8

endmodule

// File: rtl/dsi_port.sv
module dsi_port #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              in_data,
    input  logic              is_read,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              rd_rise,
    input  logic              rd_fall,
    input  logic              din,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              dout,
    output logic              oe
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wbuf, rbuf, fetched;
    logic [IDX_W-1:0]  widx, ridx;
    logic              rdone;
    logic              in_range, rd_go, wr_go, wr_last;

    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(DEPTH - 1)) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        in_range    = ({1'b0, addr} < LIMIT);
        rd_go       = !cs_n && in_data && rd_fall && !rdone;
        wr_go       = !cs_n && in_data && !is_read && wr_rise;
        wr_last     = wr_go && (widx == IDX_W'(DATA_W - 1));
        fetched     = in_range ? mem_rd_data : '0;
        mem_rd_en   = rd_go && (ridx == '0) && in_range;
        mem_wr_en   = wr_last && in_range;
        mem_wr_data = wbuf;
        mem_wr_data[widx] = din;
    end

    assign mem_addr = addr;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            addr  <= '0;
            wbuf  <= '0;
            rbuf  <= '0;
            widx  <= '0;
            ridx  <= '0;
            rdone <= 1'b0;
            dout  <= 1'b0;
            oe    <= 1'b0;
        end else begin
            if (addr_load) begin
                addr  <= addr_val;
                widx  <= '0;
                ridx  <= '0;
                rdone <= 1'b0;
            end
            if (rd_go) begin
                oe <= 1'b1;
                if (ridx == '0) begin
                    rbuf <= fetched;
                    dout <= fetched[0];
                end else begin
                    dout <= rbuf[ridx];
                end
                if (ridx == IDX_W'(DATA_W - 1)) begin
                    ridx  <= '0;
                    rdone <= 1'b1;
                end else begin
                    ridx <= ridx + 1'b1;
                end
            end
            if (in_data && rd_rise && rdone && oe) begin
                oe <= 1'b0;
                if (is_read) begin
                    rdone <= 1'b0;
                    addr  <= step(addr);
                end
            end
            if (in_data && wr_fall) oe <= 1'b0;
            if (wr_go) begin
                wbuf <= mem_wr_data;
                if (wr_last) begin
                    widx  <= '0;
                    ridx  <= '0;
                    rdone <= 1'b0;
                    addr  <= step(addr);
                end else begin
                    widx <= widx + 1'b1;
                end
            end
        end
    end

    AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        oe |-> in_data);                                             // R11
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));                                  // R6
    AST_ADDR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && in_data && !wr_rise && !rd_rise && !addr_load)
            |=> $stable(mem_addr));                                  // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_addr == ADDR_W'(DEPTH - 1))
            |=> (mem_addr == '0));                                   // R9

endmodule

// File: rtl/disp_serial_if.sv
module disp_serial_if
    import dsi_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 4,
    parameter int CMD_W  = 9,
    parameter int DEPTH  = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              dat_in,
    output logic              dat_out,
    output logic              dat_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_code
);
    logic [1:0]        rise, fall;
    phase_t            phase;
    kind_t             kind;
    logic              addr_load;
    logic [ADDR_W-1:0] addr_val;

    dsi_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_n ({rd_n, wr_n}),
        .rise   (rise),
        .fall   (fall)
    );

    dsi_frame #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_rise   (rise[0]),
        .din       (dat_in),
        .phase     (phase),
        .kind      (kind),
        .addr_load (addr_load),
        .addr_val  (addr_val),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    dsi_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_port (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .in_data     (phase == PH_DATA),
        .is_read     (kind == K_RD),
        .addr_load   (addr_load),
        .addr_val    (addr_val),
        .wr_rise     (rise[0]),
        .wr_fall     (fall[0]),
        .rd_rise     (rise[1]),
        .rd_fall     (fall[1]),
        .din         (dat_in),
        .mem_rd_data (mem_rd_data),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .dout        (dat_out),
        .oe          (dat_oe)
    );

    AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dat_oe && !cmd_valid));                           // R1
    AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!mem_rd_en && !mem_wr_en));                        // R1

endmodule

// File: tb/test_disp_serial_if.sv
module test_disp_serial_if;
    localparam int AW = 7, DW = 4, CW = 9, DEPTH = 96;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, cs_n, wr_n, rd_n, dat_in, dat_out, dat_oe;
    logic [AW-1:0] mem_addr;
    logic mem_rd_en, mem_wr_en, cmd_valid;
    logic [DW-1:0] mem_rd_data, mem_wr_data;
    logic [CW-1:0] cmd_code;

    logic [DW-1:0] mem_m [0:127];
    logic [DW-1:0] exp_m [0:127];
    logic [CW-1:0] cmd_log [0:15];
    int n_chk = 0, n_bad = 0, n_wr = 0, n_rd = 0, n_cmd = 0;
    bit done = 0;

    disp_serial_if i_disp_serial_if (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    assign mem_rd_data = mem_m[mem_addr];

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_wr_en) begin
                mem_m[mem_addr] <= mem_wr_data;
                n_wr++;
            end
            if (mem_rd_en) n_rd++;
            if (cmd_valid) begin
                cmd_log[n_cmd[3:0]] <= cmd_code;
                n_cmd++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wbit(input logic b);
        dat_in = b; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) wbit(v[i]);
    endtask

    task automatic rbit(output logic b, output logic o);
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        b = dat_out; o = dat_oe;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_nib(output logic [3:0] v, output logic oe_all);
        logic b, o;
        oe_all = 1'b1;
        for (int k = 0; k < 4; k++) begin
            rbit(b, o);
            v[k] = b;
            oe_all = oe_all & o;
        end
    endtask

    task automatic write_nib(input logic [3:0] v);
        for (int k = 0; k < 4; k++) wbit(v[k]);
    endtask

    task automatic sel;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] nib, d;
        logic [3:0] vals [4];
        logic oe_all;
        logic [8:0] cc [3];
        int w0, r0, c0, a;
        void'($urandom(32'd2024));
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; dat_in = 1'b0;
        for (int i = 0; i < 128; i++) begin
            d = (i < DEPTH) ? 4'($urandom) : 4'hF;
            mem_m[i] = d; exp_m[i] = d;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: idle after reset
        chk("R1 oe", dat_oe, 0);
        chk("R1 strobes", n_wr + n_rd + n_cmd, 0);

        // R3/R4: single write, value distinguishes bit order
        w0 = n_wr;
        sel(); send_bits(3'b101, 3); send_bits(16'd5, 7); write_nib(4'hA); desel();
        exp_m[5] = 4'hA;
        chk("R3 data order", mem_m[5], exp_m[5]);
        chk("R4 write strobe count", n_wr - w0, 1);

        // R4/R9: burst write across the wrap point
        w0 = n_wr;
        sel(); send_bits(3'b101, 3); send_bits(16'd93, 7);
        for (int k = 0; k < 4; k++) begin
            vals[k] = 4'($urandom);
            write_nib(vals[k]);
        end
        desel();
        for (int k = 0; k < 4; k++) exp_m[(93 + k) % DEPTH] = vals[k];
        for (int k = 0; k < 4; k++)
            chk("R9 burst write", mem_m[(93 + k) % DEPTH], exp_m[(93 + k) % DEPTH]);
        chk("R4 burst strobes", n_wr - w0, 4);

        // R5/R9/R11: burst read across the wrap point
        r0 = n_rd;
        sel(); send_bits(3'b110, 3); send_bits(16'd93, 7);
        for (int k = 0; k < 4; k++) begin
            read_nib(nib, oe_all);
            chk("R5 burst read", nib, exp_m[(93 + k) % DEPTH]);
            chk("R11 oe during nibble", oe_all, 1);
            chk("R11 oe after nibble", dat_oe, 0);
        end
        desel();
        chk("R5 read strobes", n_rd - r0, 4);

        // R6: read-modify-write at 10 and 11
        sel(); send_bits(3'b101, 3); send_bits(16'd10, 7);
        read_nib(nib, oe_all);
        chk("R6 rmw old value", nib, exp_m[10]);
        d = ~exp_m[10];
        write_nib(d); exp_m[10] = d;
        chk("R11 oe after rmw write", dat_oe, 0);
        read_nib(nib, oe_all);
        chk("R6 rmw next address", nib, exp_m[11]);
        d = exp_m[11] ^ 4'h6;
        write_nib(d); exp_m[11] = d;
        desel();
        chk("R6 rmw stored 10", mem_m[10], exp_m[10]);
        chk("R6 rmw stored 11", mem_m[11], exp_m[11]);

        // R7: successive commands without repeated identifier
        c0 = n_cmd;
        cc[0] = 9'h0_03; cc[1] = 9'h1A5; cc[2] = 9'($urandom);
        sel(); send_bits(3'b100, 3);
        for (int k = 0; k < 3; k++) send_bits(16'(cc[k]), 9);
        desel();
        chk("R7 command count", n_cmd - c0, 3);
        for (int k = 0; k < 3; k++) chk("R7 command code", cmd_log[(c0 + k) % 16], cc[k]);

        // R2: unknown identifiers produce nothing
        w0 = n_wr; r0 = n_rd; c0 = n_cmd;
        sel(); send_bits(3'b111, 3); send_bits(16'hB5A3, 16); read_nib(nib, oe_all); desel();
        sel(); send_bits(3'b000, 3); send_bits(16'h3C5F, 16); desel();
        chk("R2 bad id silent", (n_wr - w0) + (n_rd - r0) + (n_cmd - c0), 0);
        chk("R2 bad id no drive", oe_all, 0);

        // R8: deselect mid-address, mid-nibble and mid-command
        w0 = n_wr; c0 = n_cmd;
        sel(); send_bits(3'b101, 3); send_bits(16'h5, 4); desel();
        sel(); send_bits(3'b101, 3); send_bits(16'd30, 7); wbit(~exp_m[30][0]); wbit(1'b1); desel();
        sel(); send_bits(3'b100, 3); send_bits(16'h15, 5); desel();
        sel(); send_bits(3'b100, 3); send_bits(16'h0E3, 9); desel();
        chk("R8 aborted write", n_wr - w0, 0);
        chk("R8 memory untouched", mem_m[30], exp_m[30]);
        chk("R8 one command", n_cmd - c0, 1);
        chk("R8 command code", cmd_log[c0 % 16], 9'h0E3);

        // R10: out-of-range accesses
        w0 = n_wr; r0 = n_rd;
        sel(); send_bits(3'b101, 3); send_bits(16'd100, 7); write_nib(4'h5); desel();
        chk("R10 no write strobe", n_wr - w0, 0);
        sel(); send_bits(3'b110, 3); send_bits(16'd110, 7); read_nib(nib, oe_all); desel();
        chk("R10 read returns zero", nib, 0);
        chk("R10 no read strobe", n_rd - r0, 0);

        // R3/R5: random write then read back
        for (int t = 0; t < 24; t++) begin
            a = $urandom_range(DEPTH - 1, 0);
            d = 4'($urandom);
            sel(); send_bits(3'b101, 3); send_bits(16'(a), 7); write_nib(d); desel();
            exp_m[a] = d;
            sel(); send_bits(3'b110, 3); send_bits(16'(a), 7); read_nib(nib, oe_all); desel();
            chk("R5 random readback", nib, exp_m[a]);
            chk("R3 random stored", mem_m[a], exp_m[a]);
        end

        chk("R1 idle at end", dat_oe, 0);
        done = 1;
        summary();
        $finish;
    end

endmodule